// File: doc/BRIEF.md
# Single-dword completer request handler

This block is the receive-side control of an endpoint that only completes requests from a host. Memory requests arrive already decoded, as a kind, an address, a byte length, byte enables, write data and a tag. A request that fits in one 32-bit dword becomes one transaction on a 32-bit memory-mapped master port that has wait-request flow control. A read then sends a completion carrying the fetched data back toward the host.

Requests that the handler cannot serve are refused by fixed rules:

- Over-length reads and all non-memory non-posted kinds get a completer-abort completion.
- Over-length writes and posted messages vanish without trace.

The handler works on one request at a time. It takes no new request until the current bus access and any completion handshake are finished.

Top module: `sdw_req_handler`

## Requirements
- R1: While reset is high and in the cycle after it falls, `req_ready` is 1 and `bus_read`, `bus_write` and `cpl_valid` are 0. Reset is synchronous and active high, and a reset in the middle of an access abandons that access.
- R2: `req_ready` is 1 only when no bus access and no completion are pending. It is 0 in every cycle where `bus_read`, `bus_write` or `cpl_valid` is 1.
- R3: A request of kind 1 (memory write) with `req_len` from 0 to 4 bytes causes exactly one bus write. That write carries the request's address, data and byte enables, and no completion is produced.
- R4: A request of kind 0 (memory read) with `req_len` from 0 to 4 bytes causes exactly one bus read with the request's address and byte enables. It is followed by one completion with status 3'b000, the request tag, `cpl_has_data`=1, byte count 4, and the read data.
- R5: While `bus_waitreq` is 1, the active strobe stays asserted and address, byte enables and write data stay unchanged. Read data is taken only in the cycle where `bus_waitreq` is 0.
- R6: A memory read with `req_len` greater than 4 makes no bus access. It produces one completion with status 3'b100, the request tag, `cpl_has_data`=0, data 0 and byte count 0.
- R7: A memory write with `req_len` greater than 4 makes no bus access and produces no completion, and `req_ready` is 1 again in the next cycle.
- R8: Kinds 2 (I/O read), 3 (I/O write), 4 (config read), 5 (config write) and 7 (reserved) are non-posted. Each produces one completion with status 3'b100 and the request tag, with no bus access. Kind 6 (posted message) is discarded in the same way as R7.
- R9: A completion holds its status, tag and data until `cpl_ready` is 1. A request waiting at the input is accepted no earlier than the cycle after that handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Handler can take a request |
| req_kind | input | 3 | Request kind code (see R3, R4, R8) |
| req_addr | input | ADDR_W | Byte address |
| req_len | input | LEN_W | Request length in bytes |
| req_be | input | DATA_W/8 | Byte enables |
| req_wdata | input | DATA_W | Write data |
| req_tag | input | TAG_W | Request tag |
| bus_addr | output | ADDR_W | Master address |
| bus_be | output | DATA_W/8 | Master byte enables |
| bus_wdata | output | DATA_W | Master write data |
| bus_read | output | 1 | Master read strobe |
| bus_write | output | 1 | Master write strobe |
| bus_rdata | input | DATA_W | Master read data |
| bus_waitreq | input | 1 | Slave stall |
| cpl_valid | output | 1 | Completion present |
| cpl_ready | input | 1 | Completion taken |
| cpl_status | output | 3 | 3'b000 success, 3'b100 completer abort |
| cpl_tag | output | TAG_W | Tag of the completed request |
| cpl_data | output | DATA_W | Read data, 0 for an abort |
| cpl_has_data | output | 1 | Completion carries data |
| cpl_byte_count | output | LEN_W | 4 for a success, 0 for an abort |

## Verification
Two events can meet in one cycle. One is the completion handshake for a read. The other is a new request that has been waiting at the input since that read was accepted. The bench holds `req_valid` high with a write queued behind a read and holds `cpl_ready` low for several cycles. It then records the cycle in which the completion is taken and the cycle in which the queued write first appears on the bus. The result is judged correct only if the write shows up exactly two sampled cycles after the handshake and never while the completion is still pending.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

    typedef enum logic [2:0] {
        K_MEM_RD = 3'd0,
        K_MEM_WR = 3'd1,
        K_IO_RD  = 3'd2,
        K_IO_WR  = 3'd3,
        K_CFG_RD = 3'd4,
        K_CFG_WR = 3'd5,
        K_MSG    = 3'd6,
        K_RSVD   = 3'd7
    } req_kind_e;

    typedef enum logic [1:0] {
        ACT_DROP  = 2'd0,
        ACT_WRITE = 2'd1,
        ACT_READ  = 2'd2,
        ACT_ABORT = 2'd3
    } req_act_e;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_BUS_WRITE = 3'd1,
        ST_BUS_READ  = 3'd2,
        ST_SEND_CPL  = 3'd3,
        ST_SEND_CA   = 3'd4
    } hdl_state_e;

    localparam logic [2:0] CPL_SC = 3'b000;
    localparam logic [2:0] CPL_CA = 3'b100;

    function automatic logic kind_is_posted(input req_kind_e k);
        return (k == K_MEM_WR) || (k == K_MSG);
    endfunction

endpackage

// File: rtl/sdw_req_classify.sv
module sdw_req_classify
    import sdw_pkg::*;
#(
    parameter int LEN_W    = 12,
    parameter int DW_BYTES = 4
) (
    input  logic [2:0]       kind_i,
    input  logic [LEN_W-1:0] len_i,
    output req_act_e         act_o
);
    localparam logic [LEN_W-1:0] LEN_LIMIT = LEN_W'(DW_BYTES);

    req_kind_e kind;
    logic      fits;

    always_comb begin
        kind = req_kind_e'(kind_i);
        fits = (len_i <= LEN_LIMIT);
        unique case (kind)
            K_MEM_RD: act_o = fits ? ACT_READ : ACT_ABORT;
            K_MEM_WR: act_o = fits ? ACT_WRITE : ACT_DROP;
            default:  act_o = kind_is_posted(kind) ? ACT_DROP : ACT_ABORT;
        endcase
    end

endmodule

// File: rtl/sdw_req_fsm.sv
module sdw_req_fsm
    import sdw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    input  req_act_e          act_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BE_W-1:0]   be_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              req_ready_o,
    output logic              accept_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [BE_W-1:0]   bus_be_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    output logic              bus_read_o,
    output logic              bus_write_o,
    input  logic              bus_waitreq_i,
    output logic              rd_done_o,
    output logic              cpl_valid_o,
    input  logic              cpl_ready_i
);
    hdl_state_e state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [BE_W-1:0]   be_q;
    logic [DATA_W-1:0] wdata_q;

    assign req_ready_o = (state_q == ST_IDLE);
    assign accept_o    = req_ready_o && req_valid_i;
    assign bus_read_o  = (state_q == ST_BUS_READ);
    assign bus_write_o = (state_q == ST_BUS_WRITE);
    assign rd_done_o   = bus_read_o && !bus_waitreq_i;
    assign cpl_valid_o = (state_q == ST_SEND_CPL) || (state_q == ST_SEND_CA);
    assign bus_addr_o  = addr_q;
    assign bus_be_o    = be_q;
    assign bus_wdata_o = wdata_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept_o) begin
                    unique case (act_i)
                        ACT_WRITE: state_d = ST_BUS_WRITE;
                        ACT_READ:  state_d = ST_BUS_READ;
                        ACT_ABORT: state_d = ST_SEND_CA;
                        default:   state_d = ST_IDLE;
                    endcase
                end
            end
            ST_BUS_WRITE: if (!bus_waitreq_i) state_d = ST_IDLE;
            ST_BUS_READ:  if (!bus_waitreq_i) state_d = ST_SEND_CPL;
            ST_SEND_CPL,
            ST_SEND_CA:   if (cpl_ready_i) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            be_q    <= '0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept_o) begin
                addr_q  <= addr_i;
                be_q    <= be_i;
                wdata_q <= wdata_i;
            end
        end
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_read_o && bus_waitreq_i) |=> (bus_read_o && $stable(bus_addr_o) && $stable(bus_be_o))); // R5
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_write_o && bus_waitreq_i) |=> (bus_write_o && $stable(bus_addr_o) && $stable(bus_be_o) && $stable(bus_wdata_o))); // R5
    AST_ABORT_NO_BUS: assert property (@(posedge clk) disable iff (rst)
        (accept_o && act_i == ACT_ABORT) |=> (cpl_valid_o && !bus_read_o && !bus_write_o)); // R6
    AST_DROP_STAYS: assert property (@(posedge clk) disable iff (rst)
        (accept_o && act_i == ACT_DROP) |=> (req_ready_o && !bus_read_o && !bus_write_o && !cpl_valid_o)); // R7

endmodule

// File: rtl/sdw_cpl_reg.sv
module sdw_cpl_reg
    import sdw_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int TAG_W    = 8,
    parameter int BC_W     = 12,
    parameter int DW_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept_i,
    input  logic              abort_i,
    input  logic [TAG_W-1:0]  tag_i,
    input  logic              rd_done_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [2:0]        status_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic [DATA_W-1:0] data_o,
    output logic              has_data_o,
    output logic [BC_W-1:0]   bytes_o
);
    logic [2:0]        status_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= CPL_SC;
            tag_q    <= '0;
            data_q   <= '0;
        end else begin
            if (accept_i) tag_q <= tag_i;
            if (abort_i) begin
                status_q <= CPL_CA;
                data_q   <= '0;
            end else if (rd_done_i) begin
                status_q <= CPL_SC;
                data_q   <= rdata_i;
            end
        end
    end

    assign status_o   = status_q;
    assign tag_o      = tag_q;
    assign data_o     = data_q;
    assign has_data_o = (status_q == CPL_SC);
    assign bytes_o    = has_data_o ? BC_W'(DW_BYTES) : '0;

endmodule

// File: rtl/sdw_req_handler.sv
module sdw_req_handler
    import sdw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 12,
    parameter int TAG_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [2:0]            req_kind,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [LEN_W-1:0]      req_len,
    input  logic [DATA_W/8-1:0]   req_be,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [TAG_W-1:0]      req_tag,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic [DATA_W/8-1:0]   bus_be,
    output logic [DATA_W-1:0]     bus_wdata,
    output logic                  bus_read,
    output logic                  bus_write,
    input  logic [DATA_W-1:0]     bus_rdata,
    input  logic                  bus_waitreq,
    output logic                  cpl_valid,
    input  logic                  cpl_ready,
    output logic [2:0]            cpl_status,
    output logic [TAG_W-1:0]      cpl_tag,
    output logic [DATA_W-1:0]     cpl_data,
    output logic                  cpl_has_data,
    output logic [LEN_W-1:0]      cpl_byte_count
);
    localparam int BE_W     = DATA_W / 8;
    localparam int DW_BYTES = BE_W;

    req_act_e act;
    logic     accept;
    logic     rd_done;

    sdw_req_classify #(.LEN_W(LEN_W), .DW_BYTES(DW_BYTES)) u_classify (
        .kind_i (req_kind),
        .len_i  (req_len),
        .act_o  (act)
    );

    sdw_req_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .req_valid_i   (req_valid),
        .act_i         (act),
        .addr_i        (req_addr),
        .be_i          (req_be),
        .wdata_i       (req_wdata),
        .req_ready_o   (req_ready),
        .accept_o      (accept),
        .bus_addr_o    (bus_addr),
        .bus_be_o      (bus_be),
        .bus_wdata_o   (bus_wdata),
        .bus_read_o    (bus_read),
        .bus_write_o   (bus_write),
        .bus_waitreq_i (bus_waitreq),
        .rd_done_o     (rd_done),
        .cpl_valid_o   (cpl_valid),
        .cpl_ready_i   (cpl_ready)
    );

    sdw_cpl_reg #(.DATA_W(DATA_W), .TAG_W(TAG_W), .BC_W(LEN_W), .DW_BYTES(DW_BYTES)) u_cpl (
        .clk        (clk),
        .rst        (rst),
        .accept_i   (accept),
        .abort_i    (accept && act == ACT_ABORT),
        .tag_i      (req_tag),
        .rd_done_i  (rd_done),
        .rdata_i    (bus_rdata),
        .status_o   (cpl_status),
        .tag_o      (cpl_tag),
        .data_o     (cpl_data),
        .has_data_o (cpl_has_data),
        .bytes_o    (cpl_byte_count)
    );

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        (bus_read || bus_write || cpl_valid) |-> !req_ready); // R2
    AST_RD_EXCL_WR: assert property (@(posedge clk) disable iff (rst)
        !(bus_read && bus_write)); // R3
    AST_WR_NO_CPL: assert property (@(posedge clk) disable iff (rst)
        (bus_write && !bus_waitreq) |=> (!cpl_valid && req_ready)); // R3
    AST_READ_TO_CPL: assert property (@(posedge clk) disable iff (rst)
        (bus_read && !bus_waitreq) |=> (cpl_valid && cpl_status == CPL_SC && cpl_data == $past(bus_rdata))); // R4
    AST_CPL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && !cpl_ready) |=> (cpl_valid && $stable(cpl_status) && $stable(cpl_tag) && $stable(cpl_data))); // R9

endmodule

// File: tb/sdw_req_handler_tb_top.sv
module sdw_req_handler_tb_top;

    typedef struct packed {
        logic [2:0]  kind;
        logic [11:0] len;
        logic [3:0]  be;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [7:0]  tag;
        logic [31:0] rdata;
        logic [3:0]  stall;
        logic [3:0]  cwait;
        logic        ewr;
        logic        erd;
        logic        ecpl;
        logic [2:0]  est;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 12'd4, 4'hF, 32'h0000_1000, 32'hDEAD_BEEF, 8'h01, 32'h0, 4'd0, 4'd0, 1'b1, 1'b0, 1'b0, 3'b000},
        '{3'd1, 12'd2, 4'h3, 32'h0000_2004, 32'h1234_5678, 8'h02, 32'h0, 4'd3, 4'd0, 1'b1, 1'b0, 1'b0, 3'b000},
        '{3'd0, 12'd4, 4'hF, 32'h0000_3008, 32'h0, 8'h03, 32'hCAFE_F00D, 4'd0, 4'd0, 1'b0, 1'b1, 1'b1, 3'b000},
        '{3'd0, 12'd4, 4'hC, 32'h0000_300C, 32'h0, 8'h04, 32'hA5A5_5A5A, 4'd4, 4'd2, 1'b0, 1'b1, 1'b1, 3'b000},
        '{3'd0, 12'd8, 4'hF, 32'h0000_4000, 32'h0, 8'h05, 32'h1111_2222, 4'd0, 4'd1, 1'b0, 1'b0, 1'b1, 3'b100},
        '{3'd1, 12'd8, 4'hF, 32'h0000_5000, 32'h7777_8888, 8'h06, 32'h0, 4'd0, 4'd0, 1'b0, 1'b0, 1'b0, 3'b000},
        '{3'd2, 12'd4, 4'hF, 32'h0000_6000, 32'h0, 8'h07, 32'h0, 4'd0, 4'd0, 1'b0, 1'b0, 1'b1, 3'b100},
        '{3'd5, 12'd4, 4'hF, 32'h0000_7000, 32'h5555_6666, 8'h08, 32'h0, 4'd0, 4'd0, 1'b0, 1'b0, 1'b1, 3'b100},
        '{3'd6, 12'd4, 4'hF, 32'h0000_8000, 32'h0, 8'h09, 32'h0, 4'd0, 4'd0, 1'b0, 1'b0, 1'b0, 3'b000},
        '{3'd7, 12'd4, 4'hF, 32'h0000_9000, 32'h0, 8'h0A, 32'h0, 4'd0, 4'd1, 1'b0, 1'b0, 1'b1, 3'b100},
        '{3'd0, 12'd1, 4'h1, 32'h0000_A001, 32'h0, 8'h0B, 32'h0F0F_F0F0, 4'd1, 4'd0, 1'b0, 1'b1, 1'b1, 3'b000},
        '{3'd3, 12'd4, 4'hF, 32'h0000_B000, 32'h9999_AAAA, 8'h0C, 32'h0, 4'd2, 4'd0, 1'b0, 1'b0, 1'b1, 3'b100}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_kind = '0;
    logic [31:0] req_addr = '0;
    logic [11:0] req_len = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic [7:0]  req_tag = '0;
    logic [31:0] bus_addr;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata;
    logic        bus_read;
    logic        bus_write;
    logic [31:0] bus_rdata = '0;
    logic        bus_waitreq = 1'b0;
    logic        cpl_valid;
    logic        cpl_ready = 1'b0;
    logic [2:0]  cpl_status;
    logic [7:0]  cpl_tag;
    logic [31:0] cpl_data;
    logic        cpl_has_data;
    logic [11:0] cpl_byte_count;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    sdw_req_handler dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_addr(req_addr), .req_len(req_len), .req_be(req_be),
        .req_wdata(req_wdata), .req_tag(req_tag), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_read(bus_read), .bus_write(bus_write),
        .bus_rdata(bus_rdata), .bus_waitreq(bus_waitreq), .cpl_valid(cpl_valid),
        .cpl_ready(cpl_ready), .cpl_status(cpl_status), .cpl_tag(cpl_tag),
        .cpl_data(cpl_data), .cpl_has_data(cpl_has_data), .cpl_byte_count(cpl_byte_count)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int nwr = 0, nrd = 0, ncpl = 0, hold_err = 0, busy_err = 0;
        int stall_left, cw_left;
        logic [31:0] w_addr = '0, w_data = '0, r_addr = '0;
        logic [3:0]  w_be = '0, r_be = '0;
        logic [2:0]  c_st = '0;
        logic [7:0]  c_tag = '0;
        logic [31:0] c_data = '0;
        logic        c_hd = 1'b0;
        logic [11:0] c_bc = '0;
        stall_left = int'(v.stall);
        cw_left    = int'(v.cwait);
        @(negedge clk);
        chk($sformatf("R2 idle ready before vec %0d", idx), {31'd0, req_ready}, 32'd1);
        req_kind = v.kind; req_len = v.len; req_be = v.be; req_addr = v.addr;
        req_wdata = v.wdata; req_tag = v.tag; req_valid = 1'b1;
        bus_waitreq = 1'b0; cpl_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 30; k++) begin
            if (bus_read || bus_write) begin
                if (req_ready) busy_err++;
                if (bus_addr !== v.addr || bus_be !== v.be) hold_err++;
                if (bus_write && bus_wdata !== v.wdata) hold_err++;
                if (stall_left > 0) begin
                    bus_waitreq = 1'b1; bus_rdata = ~v.rdata; stall_left--;
                end else begin
                    bus_waitreq = 1'b0; bus_rdata = v.rdata;
                    if (bus_write) begin nwr++; w_addr = bus_addr; w_data = bus_wdata; w_be = bus_be; end
                    else begin nrd++; r_addr = bus_addr; r_be = bus_be; end
                end
            end else bus_waitreq = 1'b0;
            if (cpl_valid) begin
                if (req_ready) busy_err++;
                if (cw_left > 0) begin cpl_ready = 1'b0; cw_left--; end
                else begin
                    cpl_ready = 1'b1; ncpl++;
                    c_st = cpl_status; c_tag = cpl_tag; c_data = cpl_data;
                    c_hd = cpl_has_data; c_bc = cpl_byte_count;
                end
            end else cpl_ready = 1'b0;
            @(negedge clk);
        end
        bus_waitreq = 1'b0; cpl_ready = 1'b0;
        chk($sformatf("R3/R7 write count vec %0d", idx), nwr, {31'd0, v.ewr});
        chk($sformatf("R4/R6 read count vec %0d", idx), nrd, {31'd0, v.erd});
        chk($sformatf("R8 completion count vec %0d", idx), ncpl, {31'd0, v.ecpl});
        chk($sformatf("R5 strobe hold vec %0d", idx), hold_err, 0);
        chk($sformatf("R2 ready low while busy vec %0d", idx), busy_err, 0);
        chk($sformatf("R7 ready after vec %0d", idx), {31'd0, req_ready}, 32'd1);
        if (v.ewr) begin
            chk($sformatf("R3 write addr vec %0d", idx), w_addr, v.addr);
            chk($sformatf("R3 write data vec %0d", idx), w_data, v.wdata);
            chk($sformatf("R3 write be vec %0d", idx), {28'd0, w_be}, {28'd0, v.be});
        end
        if (v.erd) begin
            chk($sformatf("R4 read addr vec %0d", idx), r_addr, v.addr);
            chk($sformatf("R4 read be vec %0d", idx), {28'd0, r_be}, {28'd0, v.be});
        end
        if (v.ecpl) begin
            chk($sformatf("R6/R8 cpl status vec %0d", idx), {29'd0, c_st}, {29'd0, v.est});
            chk($sformatf("R4 cpl tag vec %0d", idx), {24'd0, c_tag}, {24'd0, v.tag});
            chk($sformatf("R5 cpl data vec %0d", idx), c_data, (v.est == 3'b000) ? v.rdata : 32'd0);
            chk($sformatf("R6 cpl has_data vec %0d", idx), {31'd0, c_hd}, {31'd0, (v.est == 3'b000)});
            chk($sformatf("R4 cpl byte count vec %0d", idx), {20'd0, c_bc}, (v.est == 3'b000) ? 32'd4 : 32'd0);
        end
    endtask

    initial begin : watchdog
        wait (cycles > 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int hs, first_wr, early, cw;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready after reset", {31'd0, req_ready}, 32'd1);
        chk("R1 strobes after reset", {30'd0, bus_read, bus_write}, 32'd0);
        chk("R1 cpl_valid after reset", {31'd0, cpl_valid}, 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R9: a write queued behind a back-pressured read completion
        @(negedge clk);
        req_kind = 3'd0; req_len = 12'd4; req_be = 4'hF; req_addr = 32'h0000_C000;
        req_tag = 8'h21; bus_rdata = 32'h2468_ACE0; req_valid = 1'b1;
        bus_waitreq = 1'b0; cpl_ready = 1'b0;
        @(negedge clk);
        req_kind = 3'd1; req_addr = 32'h0000_4440; req_wdata = 32'h0BAD_F00D; req_tag = 8'h22;
        hs = -1; first_wr = -1; early = 0; cw = 3;
        for (int k = 0; k < 20; k++) begin
            if (cpl_valid && hs < 0) begin
                if (cw > 0) begin cpl_ready = 1'b0; cw--; end
                else begin cpl_ready = 1'b1; hs = k; end
            end else cpl_ready = 1'b0;
            if (bus_write) begin
                if (hs < 0) early++;
                if (first_wr < 0) begin
                    first_wr = k;
                    chk("R9 queued write data", bus_wdata, 32'h0BAD_F00D);
                end
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        cpl_ready = 1'b0; req_valid = 1'b0;
        chk("R9 handshake seen", {31'd0, (hs >= 0)}, 32'd1);
        chk("R9 write not before handshake", early, 0);
        chk("R9 write cycle after handshake", first_wr, hs + 2);

        // R1: reset during a stalled read
        @(negedge clk);
        req_kind = 3'd0; req_len = 12'd4; req_addr = 32'h0000_D000; req_tag = 8'h31; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; bus_waitreq = 1'b1;
        @(negedge clk);
        chk("R5 read held during stall", {31'd0, bus_read}, 32'd1);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 ready during reset", {31'd0, req_ready}, 32'd1);
        rst = 1'b0; bus_waitreq = 1'b0;
        @(negedge clk);
        chk("R1 abandoned read after reset", {30'd0, bus_read, cpl_valid}, 32'd0);
        chk("R1 ready after mid reset", {31'd0, req_ready}, 32'd1);
        repeat (3) @(negedge clk);
        chk("R1 no late completion", {31'd0, cpl_valid}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule